// File: doc/BRIEF.md
# Flushable L0 Instruction Cache

This block is a tiny direct-mapped instruction cache that sits in the fetch stage of a pipelined core. Both the set index and the tag are taken straight from the virtual fetch address, so a lookup completes in the same cycle the address is presented and never waits for address translation. On a hit it returns one 32-bit instruction word, chosen from a 16-byte line that holds four words. Tags and line data live in small arrays with a combinational read path. The per-line valid bits are held in flip-flops.

On an aligned miss the cache raises a request for the whole line at its line-aligned virtual address. It holds that request until the next-level memory answers with a one-cycle pulse that carries all 16 bytes. The fetch stage keeps presenting the same address, and it hits from the cycle after the fill. A single `flush` input clears every valid bit in one cycle. The surrounding core drives it on a privilege-state change, on an instruction-stream fence and on an address-translation fence. The capacity is a parameter of 64 lines (1 KiB) by default. Elaboration rejects any size above 4 KiB, and any line count that is not a power of two.

Top module: `l0_icache`

## Requirements
- R1: After reset every line is invalid: `fetch_hit` is 0 for any address and `refill_req` is 0.
- R2: A hit is combinational in the cycle of the lookup. `fetch_word` is word k of the stored line, where k = `fetch_addr[3:2]` and word k is `refill_line[32k+31:32k]`.
- R3: An aligned fetch that misses while the cache is idle raises `refill_req` on the next cycle. `refill_addr` equals `{fetch_addr[31:4],4'b0}`, and both stay unchanged until `refill_valid` is seen.
- R4: A `refill_valid` pulse while a request is outstanding stores the line and drops `refill_req` on the next cycle. The same address then hits from that next cycle onward.
- R5: The mapping is direct: the line index is `fetch_addr[9:4]` at the default size, and the tag is `fetch_addr[31:10]`. Two addresses with the same index but different tags evict each other, and an address whose tag differs from the stored tag misses.
- R6: Lines at different indices are held at the same time without disturbing each other.
- R7: `flush` clears all valid bits in one cycle. `fetch_hit` is forced to 0 in the flush cycle, no refill starts in that cycle, and every line filled earlier misses afterwards.
- R8: A flush during an outstanding refill takes priority. The line that returns is written but not marked valid, so the pending fetch misses again and issues a new request.
- R9: A fetch with `fetch_addr[1:0]` not zero never hits and never raises `refill_req`.
- R10: While `fetch_valid` is 0, `fetch_hit` is 0 and no refill is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate every line in one cycle |
| fetch_valid | input | 1 | A fetch lookup is requested |
| fetch_addr | input | 32 | Virtual fetch address |
| fetch_hit | output | 1 | Lookup hit; `fetch_word` is valid |
| fetch_word | output | 32 | Instruction word on a hit |
| refill_req | output | 1 | Line refill outstanding |
| refill_addr | output | 32 | Line-aligned virtual address of the refill |
| refill_valid | input | 1 | One-cycle pulse delivering the refill line |
| refill_line | input | 128 | Refill data, word 0 in the low bits |

## Verification
On every cycle the assertions check the refill handshake:
- the request is held, with a steady, line-aligned address, until the data returns;
- the request drops right after the data returns;
- a flush leaves no valid bit set on the next cycle;
- no misaligned fetch ever hits.

Only the directed scenarios can show the data-path behaviour:
- the right word comes back for each offset;
- lines with the same index evict each other, while lines at different indices stay resident;
- a line that returns after a flush stays invalid and forces a second request.

// File: rtl/l0ic_pkg.sv
package l0ic_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned LINE_WORDS = 4;
   localparam int unsigned LINE_W     = WORD_W * LINE_WORDS;
   localparam int unsigned LINE_BYTES = LINE_W / 8;
   localparam int unsigned OFS_W      = $clog2(LINE_BYTES);
   localparam int unsigned MAX_BYTES  = 4096;

   typedef enum logic [0:0] {
      FILL_IDLE = 1'b0,
      FILL_WAIT = 1'b1
   } fill_state_e;
endpackage

// File: rtl/l0ic_lutram.sv
module l0ic_lutram #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIDTH = 22,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/l0ic_valid_bits.sv
module l0ic_valid_bits #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_all,
   input  logic             set_en,
   input  logic [AW-1:0]    set_idx,
   output logic [DEPTH-1:0] valid
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        valid[i] <= 1'b0;
         else if (clear_all)                valid[i] <= 1'b0;
         else if (set_en && set_idx == i)   valid[i] <= 1'b1;
      end
   end

   AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> (valid == '0)); // R7
endmodule

// File: rtl/l0ic_refill_ctl.sv
module l0ic_refill_ctl
   import l0ic_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned LA_W  = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lookup_miss,
   input  logic [LA_W-1:0]   miss_line,
   input  logic              refill_valid,
   output logic              refill_req,
   output logic [ADDR_W-1:0] refill_addr,
   output logic              fill_we,
   output logic              fill_mark
);
   fill_state_e      state_q;
   logic [LA_W-1:0]  line_q;
   logic             poison_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FILL_IDLE;
         line_q   <= '0;
         poison_q <= 1'b0;
      end else begin
         unique case (state_q)
            FILL_IDLE: begin
               poison_q <= 1'b0;
               if (lookup_miss) begin
                  state_q <= FILL_WAIT;
                  line_q  <= miss_line;
               end
            end
            FILL_WAIT: begin
               if (refill_valid) begin
                  state_q  <= FILL_IDLE;
                  poison_q <= 1'b0;
               end else if (flush) begin
                  poison_q <= 1'b1;
               end
            end
            default: state_q <= FILL_IDLE;
         endcase
      end
   end

   assign refill_req  = (state_q == FILL_WAIT);
   assign refill_addr = {line_q, {OFS_W{1'b0}}};
   assign fill_we     = refill_req && refill_valid;
   assign fill_mark   = fill_we && !poison_q && !flush;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req && !refill_valid |=> refill_req); // R3
   AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req && !refill_valid |=> $stable(refill_addr)); // R3
   AST_REQ_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req |-> (refill_addr[OFS_W-1:0] == '0)); // R3
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req && refill_valid |=> !refill_req); // R4
endmodule

// File: rtl/l0_icache.sv
module l0_icache
   import l0ic_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_LINES = 64,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES),
   localparam int unsigned TAG_W    = ADDR_W - IDX_W - OFS_W,
   localparam int unsigned LA_W     = ADDR_W - OFS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                fetch_valid,
   input  logic [ADDR_W-1:0]   fetch_addr,
   output logic                fetch_hit,
   output logic [WORD_W-1:0]   fetch_word,
   output logic                refill_req,
   output logic [ADDR_W-1:0]   refill_addr,
   input  logic                refill_valid,
   input  logic [LINE_W-1:0]   refill_line
);
   if (NUM_LINES * LINE_BYTES > MAX_BYTES) begin : g_too_big
      $error("l0_icache: capacity above 4 KiB needs aliasing protection");
   end
   if ((1 << IDX_W) != NUM_LINES) begin : g_not_pow2
      $error("l0_icache: NUM_LINES must be a power of two");
   end

   logic [IDX_W-1:0]     lk_idx, wr_idx;
   logic [TAG_W-1:0]     lk_tag, wr_tag, tag_rd;
   logic [LINE_W-1:0]    line_rd;
   logic [NUM_LINES-1:0] valid;
   logic                 aligned, lookup_miss, fill_we, fill_mark;
   logic [WORD_W-1:0]    words [LINE_WORDS];

   assign lk_idx  = fetch_addr[OFS_W +: IDX_W];
   assign lk_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign wr_idx  = refill_addr[OFS_W +: IDX_W];
   assign wr_tag  = refill_addr[ADDR_W-1 -: TAG_W];
   assign aligned = (fetch_addr[1:0] == 2'b00);

   l0ic_lutram #(.DEPTH(NUM_LINES), .WIDTH(TAG_W)) u_tags (
      .clk(clk), .we(fill_we), .waddr(wr_idx), .wdata(wr_tag),
      .raddr(lk_idx), .rdata(tag_rd));

   l0ic_lutram #(.DEPTH(NUM_LINES), .WIDTH(LINE_W)) u_data (
      .clk(clk), .we(fill_we), .waddr(wr_idx), .wdata(refill_line),
      .raddr(lk_idx), .rdata(line_rd));

   l0ic_valid_bits #(.DEPTH(NUM_LINES)) u_valid (
      .clk(clk), .rst_n(rst_n), .clear_all(flush),
      .set_en(fill_mark), .set_idx(wr_idx), .valid(valid));

   l0ic_refill_ctl #(.ADDR_W(ADDR_W)) u_refill (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lookup_miss(lookup_miss), .miss_line(fetch_addr[ADDR_W-1:OFS_W]),
      .refill_valid(refill_valid), .refill_req(refill_req),
      .refill_addr(refill_addr), .fill_we(fill_we), .fill_mark(fill_mark));

   for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word
      assign words[k] = line_rd[k*WORD_W +: WORD_W];
   end

   assign fetch_hit   = fetch_valid && aligned && !flush && valid[lk_idx] && (tag_rd == lk_tag);
   assign fetch_word  = words[fetch_addr[OFS_W-1:2]];
   assign lookup_miss = fetch_valid && aligned && !flush && !fetch_hit;

   always_comb begin
      if (rst_n && fetch_valid && !aligned)
         AST_MISALIGNED_NO_HIT: assert (!fetch_hit); // R9
   end

   AST_NO_HIT_WHEN_IDLE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> !fetch_hit); // R10
   AST_NO_HIT_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !fetch_hit); // R7
endmodule

// File: tb/l0_icache_bench.sv
module l0_icache_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         flush = 1'b0;
   logic         fetch_valid = 1'b0;
   logic [31:0]  fetch_addr = '0;
   logic         fetch_hit;
   logic [31:0]  fetch_word;
   logic         refill_req;
   logic [31:0]  refill_addr;
   logic         refill_valid = 1'b0;
   logic [127:0] refill_line = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   l0_icache u_l0_icache (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_hit(fetch_hit), .fetch_word(fetch_word),
      .refill_req(refill_req), .refill_addr(refill_addr),
      .refill_valid(refill_valid), .refill_line(refill_line));

   function automatic logic [31:0] mem_word(logic [31:0] a, int k);
      return {a[31:4], 4'h0} ^ (32'h1357_9BDF * (k + 1));
   endfunction

   function automatic logic [127:0] mem_line(logic [31:0] a);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = mem_word(a, k);
      return l;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // present an aligned miss, serve it, confirm the hit
   task automatic fill_line(logic [31:0] a, string req);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      #1 check({req, " miss before fill"}, fetch_hit, 0);
      @(negedge clk);
      check({req, " R3 req raised"}, refill_req, 1);
      check({req, " R3 line addr"}, refill_addr, {a[31:4], 4'h0});
      @(negedge clk);
      check({req, " R3 req held"}, refill_req, 1);
      check({req, " R3 addr held"}, refill_addr, {a[31:4], 4'h0});
      refill_valid = 1'b1; refill_line = mem_line(a);
      @(negedge clk);
      refill_valid = 1'b0;
      check({req, " R4 req dropped"}, refill_req, 0);
      #1 check({req, " R4 hit after fill"}, fetch_hit, 1);
      check({req, " R2 word"}, fetch_word, mem_word(a, a[3:2]));
   endtask

   task automatic probe(logic [31:0] a, logic exp_hit, string req);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      #1 check({req, " hit"}, fetch_hit, exp_hit);
      if (exp_hit) check({req, " word"}, fetch_word, mem_word(a, a[3:2]));
      fetch_valid = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      fetch_valid = 1'b1; fetch_addr = 32'h0000_1000;
      #1 check("R1 no hit after reset", fetch_hit, 0);
      check("R1 no request after reset", refill_req, 0);
      fetch_valid = 1'b0;
   endtask

   task automatic t_words;
      fill_line(32'h0000_1008, "R4");
      for (int k = 0; k < 4; k++) probe(32'h0000_1000 + 4 * k, 1'b1, "R2 offset");
   endtask

   task automatic t_conflict;
      fill_line(32'h0000_1404, "R5 evict");
      probe(32'h0000_1000, 1'b0, "R5 evicted tag");
      probe(32'h0000_1404, 1'b1, "R5 new tag");
      fill_line(32'h0000_1010, "R6");
      probe(32'h0000_1400, 1'b1, "R6 other index kept");
      probe(32'h0000_101C, 1'b1, "R6 second line");
   endtask

   task automatic t_misaligned;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h0000_1401;
      #1 check("R9 misaligned no hit", fetch_hit, 0);
      repeat (2) @(negedge clk);
      check("R9 misaligned no request", refill_req, 0);
      fetch_valid = 1'b0;
   endtask

   task automatic t_not_valid;
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = 32'h0000_2000;
      #1 check("R10 no hit while idle", fetch_hit, 0);
      repeat (2) @(negedge clk);
      check("R10 no request while idle", refill_req, 0);
   endtask

   task automatic t_flush;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h0000_1400; flush = 1'b1;
      #1 check("R7 hit masked in flush cycle", fetch_hit, 0);
      @(negedge clk);
      flush = 1'b0; fetch_valid = 1'b0;
      check("R7 no refill from flush cycle", refill_req, 0);
      probe(32'h0000_1400, 1'b0, "R7 line gone");
      probe(32'h0000_1010, 1'b0, "R7 second line gone");
   endtask

   task automatic t_flush_during_fill;
      logic [31:0] a = 32'h0000_3020;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      @(negedge clk);
      check("R8 req up", refill_req, 1);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      refill_valid = 1'b1; refill_line = mem_line(a);
      @(negedge clk);
      refill_valid = 1'b0;
      check("R8 req dropped after return", refill_req, 0);
      #1 check("R8 poisoned line not valid", fetch_hit, 0);
      @(negedge clk);
      check("R8 new request", refill_req, 1);
      check("R8 new request addr", refill_addr, a);
      refill_valid = 1'b1;
      @(negedge clk);
      refill_valid = 1'b0;
      #1 check("R8 hit after second fill", fetch_hit, 1);
      check("R8 word after second fill", fetch_word, mem_word(a, 0));
      fetch_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_words();
      t_conflict();
      t_misaligned();
      t_not_valid();
      t_flush();
      t_flush_during_fill();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule